// File: doc/BRIEF.md
# Serial Flash Single-Bit Read Responder

This block is the target side of a serial flash that answers only the plain single-bit read command. A host pulls chip-select low, clocks in an 8-bit command and a 24-bit address on the data-in line, and then keeps clocking. In return the block streams bytes from a small internal array on the data-out line. After each byte the read pointer moves to the next location, so one frame can run through the whole array and past its end. Releasing chip-select ends the frame at any point.

The chip-select, serial clock and data-in pins are sampled by a fast system clock through two-stage synchronizers, and SCK edges are found from the synchronized level. The data-out pin is shown as a value plus an output enable, so a pad or the enclosing level can build the tri-state driver. The block ignores a read while a busy input is asserted. A synchronous write port loads the 256-byte array.

Top module: `spi_read_responder`

## Requirements
- R1: `miso_oe` is 0 during reset, whenever chip-select is high, and within 3 `clk` cycles after chip-select rises. While `miso_oe` is 0, `miso` is 0.
- R2: The block captures the command and then the address on rising SCK edges, most significant bit first. Command 0x03 starts a read. The first byte returned is the array byte at the received address.
- R3: The block changes data-out only after falling SCK edges, most significant bit of each byte first. The value stays constant while SCK is high.
- R4: After each full byte the read pointer advances by one, and the stream continues for as long as SCK keeps toggling.
- R5: The read pointer wraps from location 0xFF to 0x00.
- R6: `miso_oe` stays 0 during the 8 command bits and the 24 address bits.
- R7: If `busy` is 1 at the rising edge that carries the eighth command bit, the read is ignored. Data-out stays released for the whole frame, and the next frame decodes normally.
- R8: Any command other than 0x03 leaves data-out released until chip-select rises. The next frame decodes normally.
- R9: If chip-select rises in the middle of a byte, the transfer stops at once. The next frame starts again at the command phase.
- R10: SCK may idle low (mode 0) or idle high (mode 3) when chip-select falls, and both return the same data. A falling edge before the first rising edge is ignored.
- R11: When `wr_en` is 1 at a rising `clk` edge, `wr_data` is written to array location `wr_addr`, and later reads return the new value.
- R12: Only address bits 7..0 select the array byte. Bits 23..8 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip-select, active low |
| sck | input | 1 | Serial clock from the host |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| miso_oe | output | 1 | Drive enable for the data-out pad |
| busy | input | 1 | Internal operation in progress; reads are rejected |
| wr_en | input | 1 | Array write strobe |
| wr_addr | input | 8 | Array write location |
| wr_data | input | 8 | Array write value |

## Verification
Each pin change reaches an output after 3 `clk` cycles: two synchronizer stages and the state register. A data bit therefore appears 3 cycles after the falling SCK edge that requests it, and the enable drops 3 cycles after chip-select rises. The bench holds every SCK phase for 8 `clk` cycles and samples at the end of each phase. It reads a data bit just before the next rising edge and reads it again just before the next falling edge, which shows the bit held steady while SCK was high. The abort check samples the enable 4 cycles after chip-select rises, which leaves one cycle of margin over the 3-cycle path.

// File: rtl/spi_read_responder.sv
module spi_read_responder #(
  parameter int OPCODE_W = 8,
  parameter logic [OPCODE_W-1:0] READ_OP = 8'h03,
  parameter int ADDR_W = 24,
  parameter int MEM_AW = 8,
  parameter int DATA_W = 8,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              mosi,
  output logic              miso,
  output logic              miso_oe,
  input  logic              busy,
  input  logic              wr_en,
  input  logic [MEM_AW-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data
);
  localparam int CNT_W  = $clog2(ADDR_W);
  localparam int DBIT_W = $clog2(DATA_W);
  localparam int SH_W   = (OPCODE_W > MEM_AW ? OPCODE_W : MEM_AW) - 1;
  localparam int DEPTH  = 1 << MEM_AW;
  localparam logic [1:0] ST_OP = 2'd0, ST_ADDR = 2'd1, ST_DATA = 2'd2, ST_DROP = 2'd3;

  logic [SYNC_N-1:0] cs_sr, sck_sr, mosi_sr;
  logic              sck_q;
  logic [1:0]        st;
  logic [CNT_W-1:0]  cnt;
  logic [SH_W-1:0]   sh;
  logic [MEM_AW-1:0] ptr;
  logic [DBIT_W-1:0] dbit;
  logic              miso_r, oe_r;
  logic [DATA_W-1:0] mem [DEPTH];

  wire cs_s   = cs_sr[SYNC_N-1];
  wire sck_s  = sck_sr[SYNC_N-1];
  wire mosi_s = mosi_sr[SYNC_N-1];
  wire rise   = sck_s & ~sck_q;
  wire fall   = ~sck_s & sck_q;
  wire [SH_W:0] sh_nx = {sh, mosi_s};

  assign miso    = miso_r;
  assign miso_oe = oe_r;

  always_ff @(posedge clk)
    if (wr_en) mem[wr_addr] <= wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_sr   <= '1;
      sck_sr  <= '0;
      mosi_sr <= '0;
      sck_q   <= 1'b0;
    end else begin
      cs_sr   <= {cs_sr[SYNC_N-2:0], cs_n};
      sck_sr  <= {sck_sr[SYNC_N-2:0], sck};
      mosi_sr <= {mosi_sr[SYNC_N-2:0], mosi};
      sck_q   <= sck_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_OP;
      cnt    <= '0;
      sh     <= '0;
      ptr    <= '0;
      dbit   <= '0;
      miso_r <= 1'b0;
      oe_r   <= 1'b0;
    end else if (cs_s) begin
      st     <= ST_OP;
      cnt    <= '0;
      dbit   <= '0;
      miso_r <= 1'b0;
      oe_r   <= 1'b0;
    end else begin
      case (st)
        ST_OP: if (rise) begin
          sh <= sh_nx[SH_W-1:0];
          if (cnt == CNT_W'(OPCODE_W - 1)) begin
            cnt <= '0;
            st  <= (sh_nx[OPCODE_W-1:0] == READ_OP && !busy) ? ST_ADDR : ST_DROP;
          end else cnt <= cnt + 1'b1;
        end
        ST_ADDR: if (rise) begin
          sh <= sh_nx[SH_W-1:0];
          if (cnt == CNT_W'(ADDR_W - 1)) begin
            st   <= ST_DATA;
            ptr  <= sh_nx[MEM_AW-1:0];
            dbit <= '0;
          end else cnt <= cnt + 1'b1;
        end
        ST_DATA: if (fall) begin
          oe_r   <= 1'b1;
          miso_r <= mem[ptr][DBIT_W'(DATA_W - 1) - dbit];
          dbit   <= dbit + 1'b1;
          if (dbit == DBIT_W'(DATA_W - 1)) ptr <= ptr + 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

module spi_read_responder_chk #(
  parameter int CNT_W = 5,
  parameter int MEM_AW = 8,
  parameter int DBIT_W = 3,
  parameter int OPCODE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_s,
  input logic              rise,
  input logic              fall,
  input logic [1:0]        st,
  input logic [CNT_W-1:0]  cnt,
  input logic [MEM_AW-1:0] ptr,
  input logic [DBIT_W-1:0] dbit,
  input logic              busy,
  input logic              miso,
  input logic              miso_oe
);
  AST_CS_HIGH_RELEASES: assert property (@(posedge clk) disable iff (!rst_n) cs_s |=> !miso_oe); // R1
  AST_RELEASED_LOW: assert property (@(posedge clk) disable iff (!rst_n) !miso_oe |-> !miso); // R1
  AST_OE_ONLY_DATA: assert property (@(posedge clk) disable iff (!rst_n) miso_oe |-> st == 2'd2); // R6
  AST_HOLD_NO_FALL: assert property (@(posedge clk) disable iff (!rst_n) (!cs_s && !fall) |=> $stable(miso)); // R3
  AST_BUSY_REJECTS: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_s && st == 2'd0 && rise && busy && cnt == CNT_W'(OPCODE_W - 1)) |=> st == 2'd3); // R7
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_s && st == 2'd2 && fall && dbit == '1) |=> ptr == $past(ptr) + 1'b1); // R4
endmodule

bind spi_read_responder spi_read_responder_chk #(
  .CNT_W(CNT_W), .MEM_AW(MEM_AW), .DBIT_W(DBIT_W), .OPCODE_W(OPCODE_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .rise(rise), .fall(fall), .st(st), .cnt(cnt),
  .ptr(ptr), .dbit(dbit), .busy(busy), .miso(miso), .miso_oe(miso_oe)
);

// File: tb/sim_spi_read_responder.sv
`timescale 1ns/1ps
module sim_spi_read_responder;
  localparam int HALF = 40;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, mosi = 1'b0, busy = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_addr = '0, wr_data = '0;
  logic miso, miso_oe;
  logic [7:0] model [256];
  int tests = 0, failed = 0;
  logic oe_seen, hold_bad;

  spi_read_responder u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi), .miso(miso),
    .miso_oe(miso_oe), .busy(busy), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      failed++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
    model[a] = d;
  endtask

  task automatic begin_frame(input bit mode3);
    sck = mode3; #(HALF); cs_n = 1'b0; #(HALF);
  endtask

  task automatic end_frame(input bit mode3);
    #(HALF); sck = mode3; #(HALF); cs_n = 1'b1; #(2*HALF);
  endtask

  task automatic put_bit(input logic b);
    sck = 1'b0; mosi = b; #(HALF);
    if (miso_oe) oe_seen = 1'b1;
    sck = 1'b1; #(HALF);
  endtask

  task automatic get_bit(output logic b, output logic oe);
    logic again;
    sck = 1'b0; #(HALF);
    b = miso; oe = miso_oe;
    sck = 1'b1; #(HALF);
    again = miso;
    if (again !== b) hold_bad = 1'b1;
  endtask

  task automatic send_header(input logic [7:0] op, input logic [23:0] a);
    for (int i = 7; i >= 0; i--) put_bit(op[i]);
    for (int i = 23; i >= 0; i--) put_bit(a[i]);
  endtask

  task automatic get_byte(output logic [7:0] d, output logic all_oe);
    logic b, oe;
    all_oe = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b, oe); d[i] = b;
      if (!oe) all_oe = 1'b0;
    end
  endtask

  task automatic read_run(input bit mode3, input logic [23:0] a, input int n, input string req);
    logic [7:0] d, e; logic all_oe;
    oe_seen = 1'b0; hold_bad = 1'b0;
    begin_frame(mode3);
    send_header(8'h03, a);
    chk(!oe_seen, "R6 oe during header", {31'd0, oe_seen}, 0);
    for (int k = 0; k < n; k++) begin
      get_byte(d, all_oe);
      e = model[8'(a[7:0] + k)];
      chk(d == e && all_oe, req, {23'd0, all_oe, d}, {24'd1, e});
    end
    chk(!hold_bad, "R3 miso held while sck high", {31'd0, hold_bad}, 0);
    end_frame(mode3);
    chk(!miso_oe && !miso, "R1 released after frame", {30'd0, miso_oe, miso}, 0);
  endtask

  task automatic t_reset;
    chk(!miso_oe && !miso, "R1 reset state", {30'd0, miso_oe, miso}, 0);
  endtask

  task automatic t_fill;
    for (int i = 0; i < 256; i++) wr(8'(i), 8'(i * 7 + 8'h35));
  endtask

  task automatic t_mode0;
    read_run(1'b0, 24'h000010, 4, "R2 R4 R11 mode0 stream");
  endtask

  task automatic t_mode3;
    read_run(1'b1, 24'h000040, 3, "R10 mode3 stream");
  endtask

  task automatic t_wrap;
    read_run(1'b0, 24'h0000FE, 4, "R5 wrap past 0xFF");
  endtask

  task automatic t_high_bits;
    read_run(1'b1, 24'hABCD37, 2, "R12 upper address ignored");
  endtask

  task automatic t_busy;
    logic b, oe; logic any_oe;
    busy = 1'b1; any_oe = 1'b0; oe_seen = 1'b0;
    begin_frame(1'b0);
    send_header(8'h03, 24'h000020);
    for (int i = 0; i < 16; i++) begin get_bit(b, oe); if (oe) any_oe = 1'b1; end
    end_frame(1'b0);
    busy = 1'b0;
    chk(!any_oe && !oe_seen, "R7 busy frame ignored", {31'd0, any_oe | oe_seen}, 0);
    read_run(1'b0, 24'h000020, 1, "R7 read after busy");
  endtask

  task automatic t_bad_op;
    logic b, oe; logic any_oe;
    any_oe = 1'b0;
    begin_frame(1'b0);
    send_header(8'h0B, 24'h000030);
    for (int i = 0; i < 16; i++) begin get_bit(b, oe); if (oe) any_oe = 1'b1; end
    end_frame(1'b0);
    chk(!any_oe, "R8 other command released", {31'd0, any_oe}, 0);
    read_run(1'b1, 24'h000031, 2, "R8 read after other command");
  endtask

  task automatic t_abort;
    logic b, oe; logic [2:0] got;
    hold_bad = 1'b0;
    begin_frame(1'b0);
    send_header(8'h03, 24'h000050);
    for (int i = 2; i >= 0; i--) begin get_bit(b, oe); got[i] = b; end
    chk(got == model[8'h50][7:5], "R9 partial byte bits", {29'd0, got}, {29'd0, model[8'h50][7:5]});
    cs_n = 1'b1; #20;
    chk(!miso_oe, "R9 abort releases within 4 clk", {31'd0, miso_oe}, 0);
    #(2*HALF); sck = 1'b0; #(2*HALF);
    read_run(1'b0, 24'h000051, 1, "R9 next frame restarts");
  endtask

  task automatic t_overwrite;
    wr(8'h80, 8'hC3);
    wr(8'h81, 8'h3C);
    read_run(1'b0, 24'h000080, 2, "R11 rewritten bytes");
  endtask

  initial begin
    #100; rst_n = 1'b1; #100;
    t_reset();
    t_fill();
    #(2*HALF);
    t_mode0();
    t_mode3();
    t_wrap();
    t_high_bits();
    t_busy();
    t_bad_op();
    t_abort();
    t_overwrite();
    $display("[TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end

  initial begin
    #750000;
    tests++; failed++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end
endmodule